// File: doc/BRIEF.md
# Conditional Branch Sequencer for a Byte-Coded Stack Machine

This unit carries out the two conditional jumps of a byte-coded stack machine: "jump when zero" and "jump when negative". The instruction decoder hands it the opcode with a one-cycle start pulse. It also supplies the current program counter, which already points at the first operand byte, along with the stack pointer and the cached top-of-stack word. The unit pops the stack and keeps the popped word as the value under test. It refills the top-of-stack cache from data memory, then reads the 16-bit jump distance from the code stream.

A taken jump moves the program counter to the address of the opcode byte plus the signed distance. A jump that is not taken steps the program counter over both operand bytes. Code memory and data memory both answer a read in the cycle after it is issued. When the final program counter, stack pointer and top-of-stack values are in place, the unit raises a one-cycle completion pulse. Any other opcode is refused with an error pulse that reports where that opcode sits.

Top module: `stk_br_seq`

## Requirements
- R1: After reset, busy_o, done_o and illegal_o are low, and pc_o, sp_o and tos_o are zero.
- R2: An accepted instruction lowers sp_o by one. Its single data read is issued at that lowered address.
- R3: tos_o takes the data word returned by that read.
- R4: Opcode 0x99 jumps exactly when the popped top-of-stack word (tos_i at start) is zero.
- R5: Opcode 0x9B jumps exactly when the popped word is negative, meaning its bit 31 is set.
- R6: The jump distance is read from code addresses pc_i and pc_i+1, most significant byte first. The first byte is sign-extended and the second byte is zero-extended. A taken jump gives pc_o = (pc_i - 1) + the sign-extended 16-bit distance.
- R7: A jump that is not taken issues exactly one code read, at pc_i, and gives pc_o = pc_i + 2. A taken jump issues exactly two code reads.
- R8: Count the edge that samples start as edge 0. done_o is high in the cycle after edge 6 for a taken jump, and in the cycle after edge 4 for one not taken.
- R9: done_o is high for exactly one cycle per accepted instruction.
- R10: A start pulse that arrives while busy_o is high is ignored. It causes no completion, no error pulse and no change to the result.
- R11: An opcode other than 0x99 or 0x9B raises illegal_o for one cycle, in the cycle after the start edge, with illegal_addr_o = pc_i - 1. It performs no memory read, leaves pc_o, sp_o and tos_o unchanged and produces no done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle request to execute opcode_i |
| opcode_i | input | 8 | Decoded opcode byte |
| pc_i | input | W | Program counter, pointing at the first operand byte |
| sp_i | input | W | Stack pointer before the pop |
| tos_i | input | W | Cached top-of-stack word before the pop |
| code_rd_o | output | 1 | Code memory read strobe |
| code_addr_o | output | W | Code memory byte address |
| code_data_i | input | 8 | Code byte, valid one cycle after the strobe |
| dmem_rd_o | output | 1 | Data memory read strobe |
| dmem_addr_o | output | W | Data memory word address |
| dmem_data_i | input | W | Data word, valid one cycle after the strobe |
| pc_o | output | W | Program counter result |
| sp_o | output | W | Stack pointer result |
| tos_o | output | W | Top-of-stack result |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle unsupported-opcode pulse |
| illegal_addr_o | output | W | Address of the refused opcode |

## Verification
A wrong test outcome latched from the popped word shows up on pc_o at the done pulse. It also shows up two cycles earlier as one code read too many or too few. A sequencing fault in the state register moves the done pulse away from its fixed slot four or six cycles after start, or puts a memory strobe in the wrong cycle. The scoreboard times every completion against the start edge, so such faults appear within the instruction that causes them. A corrupted stack pointer or refill appears at the data read address one cycle after start and on sp_o and tos_o at completion.

// File: rtl/stk_br_pkg.sv
package stk_br_pkg;

    localparam logic [7:0] OP_BR_ZERO = 8'h99;
    localparam logic [7:0] OP_BR_NEG  = 8'h9B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POP,
        ST_POP_WAIT,
        ST_HI,
        ST_HI_WAIT,
        ST_LO,
        ST_LO_WAIT,
        ST_DONE
    } seq_state_e;

    function automatic logic is_branch_op(input logic [7:0] op);
        return (op == OP_BR_ZERO) || (op == OP_BR_NEG);
    endfunction

endpackage

// File: rtl/stk_br_cond.sv
module stk_br_cond #(
    parameter int W = 32
) (
    input  logic         neg_kind_i,
    input  logic [W-1:0] value_i,
    output logic         taken_o
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (value_i == '0);
        is_neg  = value_i[W-1];
        taken_o = neg_kind_i ? is_neg : is_zero;
    end
endmodule

// File: rtl/stk_br_disp.sv
module stk_br_disp #(
    parameter int W = 32
) (
    input  logic [7:0]   hi_i,
    input  logic [7:0]   lo_i,
    output logic [W-1:0] disp_o
);
    localparam int EXT_W = W - 16;

    logic [15:0] raw;

    always_comb begin
        raw    = {hi_i, lo_i};
        disp_o = {{EXT_W{raw[15]}}, raw};
    end
endmodule

// File: rtl/stk_br_seq.sv
module stk_br_seq
    import stk_br_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [7:0]   opcode_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] sp_i,
    input  logic [W-1:0] tos_i,
    output logic         code_rd_o,
    output logic [W-1:0] code_addr_o,
    input  logic [7:0]   code_data_i,
    output logic         dmem_rd_o,
    output logic [W-1:0] dmem_addr_o,
    input  logic [W-1:0] dmem_data_i,
    output logic [W-1:0] pc_o,
    output logic [W-1:0] sp_o,
    output logic [W-1:0] tos_o,
    output logic         busy_o,
    output logic         done_o,
    output logic         illegal_o,
    output logic [W-1:0] illegal_addr_o
);

    typedef struct packed {
        seq_state_e   st;
        logic [W-1:0] pc;
        logic [W-1:0] sp;
        logic [W-1:0] tos;
        logic [W-1:0] hold;
        logic [W-1:0] base;
        logic [7:0]   hi;
        logic         neg_kind;
        logic         taken;
        logic         illegal;
        logic [W-1:0] bad_addr;
    } regs_t;

    regs_t q, d;

    logic         cond_taken;
    logic [W-1:0] disp;

    stk_br_cond #(.W(W)) cond_i (
        .neg_kind_i (q.neg_kind),
        .value_i    (q.hold),
        .taken_o    (cond_taken)
    );

    stk_br_disp #(.W(W)) disp_i (
        .hi_i   (q.hi),
        .lo_i   (code_data_i),
        .disp_o (disp)
    );

    always_comb begin
        d           = q;
        d.illegal   = 1'b0;
        code_rd_o   = 1'b0;
        dmem_rd_o   = 1'b0;
        code_addr_o = q.pc;
        dmem_addr_o = q.sp;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (is_branch_op(opcode_i)) begin
                        d.st       = ST_POP;
                        d.sp       = sp_i - 1'b1;
                        d.hold     = tos_i;
                        d.pc       = pc_i;
                        d.base     = pc_i - 1'b1;
                        d.neg_kind = (opcode_i == OP_BR_NEG);
                        d.taken    = 1'b0;
                    end else begin
                        d.illegal  = 1'b1;
                        d.bad_addr = pc_i - 1'b1;
                    end
                end
            end
            ST_POP: begin
                dmem_rd_o = 1'b1;
                d.st      = ST_POP_WAIT;
            end
            ST_POP_WAIT: begin
                d.tos   = dmem_data_i;
                d.taken = cond_taken;
                d.st    = ST_HI;
            end
            ST_HI: begin
                code_rd_o = 1'b1;
                d.pc      = q.pc + 1'b1;
                d.st      = ST_HI_WAIT;
            end
            ST_HI_WAIT: begin
                if (q.taken) begin
                    d.hi = code_data_i;
                    d.st = ST_LO;
                end else begin
                    d.pc = q.pc + 1'b1;
                    d.st = ST_DONE;
                end
            end
            ST_LO: begin
                code_rd_o = 1'b1;
                d.pc      = q.pc + 1'b1;
                d.st      = ST_LO_WAIT;
            end
            ST_LO_WAIT: begin
                d.pc = q.base + disp;
                d.st = ST_DONE;
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign pc_o           = q.pc;
    assign sp_o           = q.sp;
    assign tos_o          = q.tos;
    assign busy_o         = (q.st != ST_IDLE);
    assign done_o         = (q.st == ST_DONE);
    assign illegal_o      = q.illegal;
    assign illegal_addr_o = q.bad_addr;

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: entering the sequence lowers the stack pointer by one
    a_r2_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (sp_o == $past(sp_i) - 1'b1));

    // R2: the data read targets the lowered stack pointer
    a_r2_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_rd_o |-> (dmem_addr_o == sp_o));

    // R7: a jump not taken ends three bytes past the opcode
    a_r7_not_taken_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !q.taken) |-> (pc_o == q.base + 3));

    // R8: the two memory ports are never strobed together
    a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_rd_o, dmem_rd_o}));

    // R10: a start while busy never produces an error pulse
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !illegal_o);

    // R11: a refused opcode does not start the sequence
    a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !busy_o);

endmodule

// File: tb/stk_br_seq_tb.sv
module stk_br_seq_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [7:0]   opcode_i = '0;
    logic [W-1:0] pc_i = '0, sp_i = '0, tos_i = '0;
    logic         code_rd_o, dmem_rd_o;
    logic [W-1:0] code_addr_o, dmem_addr_o;
    logic [7:0]   code_data_i = '0;
    logic [W-1:0] dmem_data_i = '0;
    logic [W-1:0] pc_o, sp_o, tos_o, illegal_addr_o;
    logic         busy_o, done_o, illegal_o;

    always #4 clk = ~clk;

    stk_br_seq #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .pc_i(pc_i), .sp_i(sp_i), .tos_i(tos_i),
        .code_rd_o(code_rd_o), .code_addr_o(code_addr_o), .code_data_i(code_data_i),
        .dmem_rd_o(dmem_rd_o), .dmem_addr_o(dmem_addr_o), .dmem_data_i(dmem_data_i),
        .pc_o(pc_o), .sp_o(sp_o), .tos_o(tos_o), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .illegal_addr_o(illegal_addr_o)
    );

    logic [7:0]   cmem [256];
    logic [W-1:0] dmem [256];
    int           n_code = 0;
    logic [W-1:0] last_daddr = '0;
    int           cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (code_rd_o) begin
            code_data_i <= cmem[code_addr_o[7:0]];
            n_code      <= n_code + 1;
        end
        if (dmem_rd_o) begin
            dmem_data_i <= dmem[dmem_addr_o[7:0]];
            last_daddr  <= dmem_addr_o;
        end
    end

    typedef struct {
        int           cyc;
        bit           ill;
        logic [W-1:0] pc, sp, tos, daddr, bad;
        int           reads;
    } item_t;

    item_t sb_q [$];
    string sb_tag [$];

    int checks = 0;
    int errors = 0;
    logic [W-1:0] cur_pc = '0, cur_sp = '0, cur_tos = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    bit prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(!done_o, "R9", "done width", longint'(done_o), 0);
            if (done_o || illegal_o) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected completion", 1, 0);
                end else begin
                    item_t it;
                    string tg;
                    it = sb_q.pop_front();
                    tg = sb_tag.pop_front();
                    check(cyc == it.cyc, it.ill ? "R11" : "R8", "cycle", cyc, it.cyc);
                    if (it.ill) begin
                        check(illegal_o && !done_o, "R11", "illegal pulse", longint'(illegal_o), 1);
                        check(illegal_addr_o == it.bad, "R11", "illegal addr", illegal_addr_o, it.bad);
                        check(pc_o == it.pc, "R11", "pc kept", pc_o, it.pc);
                        check(sp_o == it.sp, "R11", "sp kept", sp_o, it.sp);
                        check(tos_o == it.tos, "R11", "tos kept", tos_o, it.tos);
                        check(n_code == it.reads, "R11", "no code read", n_code, it.reads);
                    end else begin
                        check(!illegal_o, "R11", "no illegal on legal op", longint'(illegal_o), 0);
                        check(pc_o == it.pc, tg, "pc", pc_o, it.pc);
                        check(sp_o == it.sp, "R2", "sp", sp_o, it.sp);
                        check(last_daddr == it.daddr, "R2", "data read addr", last_daddr, it.daddr);
                        check(tos_o == it.tos, "R3", "tos refill", tos_o, it.tos);
                        check(n_code == it.reads, "R7", "code reads", n_code, it.reads);
                    end
                end
            end
            prev_done = done_o;
        end
    end

    task automatic run_op(input logic [7:0] op, input logic [W-1:0] pc,
                          input logic [W-1:0] sp, input logic [W-1:0] tos,
                          input logic [W-1:0] newtos, input logic [7:0] hi,
                          input logic [7:0] lo, input string tag, input bit mid_start);
        item_t it;
        bit legal, tk;
        logic [W-1:0] disp, sp_new;
        legal  = (op == 8'h99) || (op == 8'h9B);
        tk     = (op == 8'h99) ? (tos == 0) : tos[W-1];
        disp   = {{(W-16){hi[7]}}, hi, lo};
        sp_new = sp - 1;
        cmem[pc[7:0]]          = hi;
        cmem[8'(pc[7:0] + 1)]  = lo;
        dmem[sp_new[7:0]]      = newtos;
        @(negedge clk);
        it.ill   = !legal;
        it.bad   = pc - 1;
        it.daddr = sp_new;
        if (legal) begin
            it.cyc   = cyc + 1 + (tk ? 6 : 4);
            it.pc    = tk ? (pc - 1 + disp) : (pc + 2);
            it.sp    = sp_new;
            it.tos   = newtos;
            it.reads = n_code + (tk ? 2 : 1);
            cur_pc = it.pc; cur_sp = it.sp; cur_tos = it.tos;
        end else begin
            it.cyc   = cyc + 1;
            it.pc    = cur_pc;
            it.sp    = cur_sp;
            it.tos   = cur_tos;
            it.reads = n_code;
        end
        sb_q.push_back(it);
        sb_tag.push_back(tag);
        start_i = 1'b1; opcode_i = op; pc_i = pc; sp_i = sp; tos_i = tos;
        @(negedge clk);
        start_i = 1'b0;
        if (mid_start) begin
            // R10: a second request while busy, with a refused opcode
            @(negedge clk);
            start_i = 1'b1; opcode_i = 8'h9A; pc_i = 32'h77; sp_i = 32'h5; tos_i = 32'h0;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            cmem[i] = 8'h00;
            dmem[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o, "R1", "busy", longint'(busy_o), 0);
        check(!done_o, "R1", "done", longint'(done_o), 0);
        check(!illegal_o, "R1", "illegal", longint'(illegal_o), 0);
        check(pc_o == 0 && sp_o == 0 && tos_o == 0, "R1", "regs", pc_o | sp_o | tos_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R4: zero test taken, positive distance
        run_op(8'h99, 32'h20, 32'h10, 32'h0, 32'h1234, 8'h00, 8'h10, "R4", 1'b0);
        // R4: nonzero not taken
        run_op(8'h99, 32'h30, 32'h0F, 32'h5, 32'hABCD, 8'h00, 8'h40, "R7", 1'b0);
        // R4: most negative is nonzero, not taken
        run_op(8'h99, 32'h50, 32'h20, 32'h80000000, 32'h9, 8'h12, 8'h34, "R4", 1'b0);
        // R5: negative taken with negative distance
        run_op(8'h9B, 32'h40, 32'h30, 32'hFFFFFFFC, 32'h66, 8'hFF, 8'hF0, "R5", 1'b0);
        // R5: zero is not negative
        run_op(8'h9B, 32'h60, 32'h31, 32'h0, 32'h77, 8'h00, 8'h08, "R5", 1'b0);
        // R5: largest positive not taken
        run_op(8'h9B, 32'h70, 32'h32, 32'h7FFFFFFF, 32'h88, 8'h00, 8'h08, "R5", 1'b0);
        // R6: low byte with top bit set is zero-extended
        run_op(8'h99, 32'h80, 32'h40, 32'h0, 32'h5A5A, 8'h01, 8'h80, "R6", 1'b0);
        // R6: most negative distance
        run_op(8'h9B, 32'h90, 32'h41, 32'h80000000, 32'h3, 8'h80, 8'h00, "R6", 1'b0);
        // R11: refused opcode
        run_op(8'h9A, 32'hA0, 32'h50, 32'h0, 32'h1, 8'h00, 8'h10, "R11", 1'b0);
        // R10: start while busy is ignored
        run_op(8'h99, 32'hB0, 32'h60, 32'h0, 32'hBEEF, 8'h00, 8'h20, "R10", 1'b1);
        run_op(8'h9B, 32'hC0, 32'h61, 32'h1, 32'hCAFE, 8'h00, 8'h20, "R10", 1'b1);
        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R10", "queue drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 20000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule